// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 18-bit words. Its write port and its read port each have their own clock, and the two clocks may be unrelated or may be the same clock. A word is stored on each rising write-clock edge that has the write enable high. A word is moved into a registered output on each rising read-clock edge that has the read enable high. The output can be switched to high impedance, which lets several buffers share one data bus.

Both pointers cross between the clock domains as Gray codes through two-flop synchronizers. The write side derives `full`, `half_full` and `almost_full` from its own pointer and from the synchronized read pointer. The read side derives `empty` and `almost_empty` in the same way from its own view.

Each almost flag is set by a threshold register. Each register has a parallel load port in the domain that uses it. A mode input chooses between two versions of the almost flags: a live decode of the level, or a version registered on the flag's own clock. A rewind input sends the read pointer back to physical location 0, so the stored words can be read a second time. The depth is a power-of-two parameter.

Top module: `xclk_fifo`

## Requirements
- R1: A rising `clk_w` edge with `wr_en` high and `full` low stores `wr_data` and advances the write pointer by one. With `wr_en` held high, a word is stored on every edge until the buffer holds DEPTH words.
- R2: A rising `clk_r` edge with `rd_en` high, `empty` low and `rewind` low loads the oldest unread word into the output register. The word is visible on `rd_data` after that edge. Words come out in the order they were written, and the output holds its value on every other edge.
- R3: While `out_en_n` is 1, every bit of `rd_data` is high impedance, and a read still advances and loads the output register. While `out_en_n` is 0, `rd_data` drives the output register.
- R4: `empty` is 1 when the read-side level is 0. The read-side level is the synchronized write pointer minus the read pointer. With a shared clock, a word written on edge k clears `empty` after edge k+2.
- R5: `full` is 1 when the write-side level equals DEPTH. The write-side level is the write pointer minus the synchronized read pointer. It never exceeds DEPTH.
- R6: A write while `full` is 1 and a read while `empty` is 1 are ignored. Neither pointer moves and the output register is unchanged.
- R7: `half_full` is 1 when the write-side level is DEPTH/2+1 or more. It is 0 when the level is DEPTH/2 or less.
- R8: With live flags, `almost_empty` is 1 when the read-side level is at or below the empty threshold. `almost_full` is 1 when the write-side level is at or above DEPTH minus the full threshold.
- R9: Both thresholds reset to OFS_RESET (default 127). A `clk_r` edge with `ae_load` high loads `ae_level`, and a `clk_w` edge with `af_load` high loads `af_level`. The new value applies to the flag from that edge onward.
- R10: With `flag_sync` = 1, each almost flag is a register on its own clock. It shows, one own-clock edge late, the decode that R8 gives. With `flag_sync` = 0, it follows the R8 decode with no extra edge.
- R11: A `clk_r` edge with `rewind` high sets the read pointer to location 0. This takes priority over a read. Later reads replay from the first word written after reset, and the flags follow the new read pointer. Rewind is valid only when no more than DEPTH words have been written since reset, with both enables low around the pulse.
- R12: `rst_n` = 0 on rising edges of both clocks is a synchronous reset. It clears both pointers and both synchronizers, sets `empty` = 1, `full` = 0, `almost_empty` = 1 and `almost_full` = 0, clears the output register to 0, and restores both thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write clock |
| clk_r | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| wr_en | input | 1 | Write enable |
| wr_data | input | 18 | Word to store |
| rd_en | input | 1 | Read enable |
| rewind | input | 1 | Rewind read pointer to location 0 (read clock) |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | 18 | Registered read word, tri-stated when disabled |
| flag_sync | input | 1 | 1: registered almost flags, 0: live almost flags |
| ae_load | input | 1 | Load the empty threshold (read clock) |
| ae_level | input | log2(DEPTH) | Empty threshold value |
| af_load | input | 1 | Load the full threshold (write clock) |
| af_level | input | log2(DEPTH) | Full threshold value |
| empty | output | 1 | No unread word on the read side |
| full | output | 1 | DEPTH words held, seen from the write side |
| half_full | output | 1 | More than half of DEPTH held |
| almost_empty | output | 1 | Read-side level at or below the empty threshold |
| almost_full | output | 1 | Write-side level at or above DEPTH minus the full threshold |

## Verification
The bench runs both ports from one clock so that every latency is a fixed number of edges:
- a read result is due one read edge after it is accepted;
- a write clears `empty` two edges later, and a read clears `full` two edges later, because of the synchronizer;
- a registered almost flag comes one edge after its live decode;
- a threshold load takes effect on its own edge.

A behavioural model with two-entry history pipelines for each pointer steps on every rising edge. All outputs are compared in the middle of the low phase, after the design and the model have both settled. Named spot checks cover:
- the overflow and underflow drops;
- the threshold reload;
- the replay after rewind;
- the high-impedance output.

// File: rtl/xcf_pkg.sv
// Shared types and Gray-code helpers for the dual-clock FIFO.
// Assumes pointer widths of 32 bits or less.
package xcf_pkg;

    // How the almost flags reach the ports
    typedef enum logic {
        FLAGS_LIVE       = 1'b0,
        FLAGS_REGISTERED = 1'b1
    } flag_mode_e;

    // Binary to reflected Gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xcf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer.
// Assumes that at most one bit of d changes per source clock edge.
// Resets synchronously to zero.
module xcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stg;
            // Single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= d;
            end
            assign q = stg;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg;
            // Shift the sampled pointer through the chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg <= '0;
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end
            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/xcf_wr_side.sv
// Write-domain control: write pointer, Gray copy for export, full,
// half-full and almost-full flags, and the full threshold register.
// Assumes DEPTH is a power of two and rgray_s is already synchronized.
module xcf_wr_side
    import xcf_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int OFS_RST = 127,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          flag_sync,
    input  logic          lvl_load,
    input  logic [AW-1:0] lvl_val,
    input  logic [PW-1:0] rgray_s,
    output logic          wr_go,
    output logic [AW-1:0] wr_addr,
    output logic [PW-1:0] wr_bin,
    output logic [PW-1:0] wr_gray,
    output logic [PW-1:0] level,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);

    localparam logic [PW-1:0] FULL_MARK = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_MARK = PW'(DEPTH / 2 + 1);
    localparam logic [AW-1:0] OFS_INIT  = AW'(OFS_RST);

    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wr_nxt;
    logic [AW-1:0] af_ofs;
    logic [PW-1:0] af_mark;
    logic          af_live;
    logic          af_q;
    flag_mode_e    mode;

    assign rbin_s  = PW'(from_gray(32'(rgray_s)));
    assign level   = wr_bin - rbin_s;
    assign full    = (level == FULL_MARK);
    assign wr_go   = wr_en & ~full;
    assign wr_nxt  = wr_bin + {{AW{1'b0}}, wr_go};
    assign wr_addr = wr_bin[AW-1:0];

    // Advance the write pointer and its Gray image together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else begin
            wr_bin  <= wr_nxt;
            wr_gray <= PW'(to_gray(32'(wr_nxt)));
        end
    end

    // Full threshold register with parallel load
    always_ff @(posedge clk) begin
        if (!rst_n)        af_ofs <= OFS_INIT;
        else if (lvl_load) af_ofs <= lvl_val;
    end

    assign af_mark   = FULL_MARK - {1'b0, af_ofs};
    assign af_live   = (level >= af_mark);
    assign half_full = (level >= HALF_MARK);

    // Registered copy of the almost-full decode
    always_ff @(posedge clk) begin
        if (!rst_n) af_q <= 1'b0;
        else        af_q <= af_live;
    end

    assign mode        = flag_mode_e'(flag_sync);
    assign almost_full = (mode == FLAGS_REGISTERED) ? af_q : af_live;

endmodule

// File: rtl/xcf_rd_side.sv
// Read-domain control: read pointer with rewind, Gray copy for export,
// empty and almost-empty flags, and the empty threshold register.
// Assumes DEPTH is a power of two and wgray_s is already synchronized.
module xcf_rd_side
    import xcf_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int OFS_RST = 127,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rewind,
    input  logic          flag_sync,
    input  logic          lvl_load,
    input  logic [AW-1:0] lvl_val,
    input  logic [PW-1:0] wgray_s,
    output logic          rd_go,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_bin,
    output logic [PW-1:0] rd_gray,
    output logic [PW-1:0] level,
    output logic          empty,
    output logic          almost_empty
);

    localparam logic [AW-1:0] OFS_INIT = AW'(OFS_RST);

    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rd_nxt;
    logic [AW-1:0] ae_ofs;
    logic          ae_live;
    logic          ae_q;
    flag_mode_e    mode;

    assign wbin_s  = PW'(from_gray(32'(wgray_s)));
    assign level   = wbin_s - rd_bin;
    assign empty   = (level == '0);
    assign rd_go   = rd_en & ~empty & ~rewind;
    assign rd_nxt  = rewind ? '0 : rd_bin + {{AW{1'b0}}, rd_go};
    assign rd_addr = rd_bin[AW-1:0];

    // Advance or rewind the read pointer and its Gray image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else begin
            rd_bin  <= rd_nxt;
            rd_gray <= PW'(to_gray(32'(rd_nxt)));
        end
    end

    // Empty threshold register with parallel load
    always_ff @(posedge clk) begin
        if (!rst_n)        ae_ofs <= OFS_INIT;
        else if (lvl_load) ae_ofs <= lvl_val;
    end

    assign ae_live = (level <= {1'b0, ae_ofs});

    // Registered copy of the almost-empty decode
    always_ff @(posedge clk) begin
        if (!rst_n) ae_q <= 1'b1;
        else        ae_q <= ae_live;
    end

    assign mode         = flag_mode_e'(flag_sync);
    assign almost_empty = (mode == FLAGS_REGISTERED) ? ae_q : ae_live;

endmodule

// File: rtl/xcf_store.sv
// Two-clock word storage with a registered read port.
// Assumes the controllers never read a location that is being written
// on the same cycle with an undefined outcome (full/empty guard this).
module xcf_store #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Store one word per accepted write
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Output register, loaded only by an accepted read
    always_ff @(posedge rclk) begin
        if (!rst_n)  q <= '0;
        else if (re) q <= mem[raddr];
    end

endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO top: storage, the two pointer domains, the Gray
// synchronizers between them and the tri-state read output.
// Assumes DEPTH is a power of two of at least 4, and that rst_n is held
// low across rising edges of both clocks.
module xclk_fifo #(
    parameter int WIDTH       = 18,
    parameter int DEPTH       = 512,
    parameter int OFS_RESET   = 127,
    parameter int SYNC_STAGES = 2,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk_w,
    input  logic             clk_r,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind,
    input  logic             out_en_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic             flag_sync,
    input  logic             ae_load,
    input  logic [AW-1:0]    ae_level,
    input  logic             af_load,
    input  logic [AW-1:0]    af_level,
    output logic             empty,
    output logic             full,
    output logic             half_full,
    output logic             almost_empty,
    output logic             almost_full
);

    logic             wr_go;
    logic             rd_go;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic [PW-1:0]    wr_bin;
    logic [PW-1:0]    rd_bin;
    logic [PW-1:0]    wr_gray;
    logic [PW-1:0]    rd_gray;
    logic [PW-1:0]    wr_gray_s;
    logic [PW-1:0]    rd_gray_s;
    logic [PW-1:0]    wr_level;
    logic [PW-1:0]    rd_level;
    logic [WIDTH-1:0] q_reg;

    xcf_wr_side #(.DEPTH(DEPTH), .OFS_RST(OFS_RESET)) u_wr (
        .clk(clk_w), .rst_n(rst_n), .wr_en(wr_en), .flag_sync(flag_sync),
        .lvl_load(af_load), .lvl_val(af_level), .rgray_s(rd_gray_s),
        .wr_go(wr_go), .wr_addr(wr_addr), .wr_bin(wr_bin), .wr_gray(wr_gray),
        .level(wr_level), .full(full), .half_full(half_full),
        .almost_full(almost_full)
    );

    xcf_rd_side #(.DEPTH(DEPTH), .OFS_RST(OFS_RESET)) u_rd (
        .clk(clk_r), .rst_n(rst_n), .rd_en(rd_en), .rewind(rewind),
        .flag_sync(flag_sync), .lvl_load(ae_load), .lvl_val(ae_level),
        .wgray_s(wr_gray_s), .rd_go(rd_go), .rd_addr(rd_addr),
        .rd_bin(rd_bin), .rd_gray(rd_gray), .level(rd_level),
        .empty(empty), .almost_empty(almost_empty)
    );

    xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(clk_r), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s)
    );

    xcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(clk_w), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s)
    );

    xcf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .wclk(clk_w), .we(wr_go), .waddr(wr_addr), .wdata(wr_data),
        .rclk(clk_r), .rst_n(rst_n), .re(rd_go), .raddr(rd_addr), .q(q_reg)
    );

    // Release the bus while the output is disabled
    assign rd_data = out_en_n ? {WIDTH{1'bz}} : q_reg;

endmodule

// File: rtl/xclk_fifo_chk.sv
// Assertion checker for xclk_fifo, attached with bind below.
// Assumes the synchronous reset is applied on both clocks.
module xclk_fifo_chk #(
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input logic          clk_w,
    input logic          clk_r,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          rewind,
    input logic          full,
    input logic          empty,
    input logic          almost_empty,
    input logic          almost_full,
    input logic [PW-1:0] wr_bin,
    input logic [PW-1:0] rd_bin,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] rd_level
);

    logic rst_seen_w;
    logic rst_seen_r;

    // Remember a reset edge in each domain
    always_ff @(posedge clk_w) rst_seen_w <= !rst_n;
    always_ff @(posedge clk_r) rst_seen_r <= !rst_n;

    // R12
    always @(negedge clk_w) begin
        if (rst_seen_w) begin
            reset_full_chk: assert (!full && !almost_full);
        end
    end

    // R12
    always @(negedge clk_r) begin
        if (rst_seen_r) begin
            reset_empty_chk: assert (empty && almost_empty && rd_bin == '0);
        end
    end

    // R1
    write_advance_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr_en && !full) |=> wr_bin == $past(wr_bin) + 1'b1);

    // R6
    no_overflow_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        (wr_en && full) |=> $stable(wr_bin));

    // R6
    no_underflow_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
        (rd_en && empty && !rewind) |=> $stable(rd_bin));

    // R4
    gray_step_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R5
    depth_bound_chk: assert property (@(posedge clk_w) disable iff (!rst_n)
        wr_level <= PW'(DEPTH));

    // R4
    empty_level_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
        empty |-> rd_level == '0);

    // R11
    rewind_home_chk: assert property (@(posedge clk_r) disable iff (!rst_n)
        rewind |=> rd_bin == '0);

endmodule

bind xclk_fifo xclk_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk_w(clk_w), .clk_r(clk_r), .rst_n(rst_n), .wr_en(wr_en),
    .rd_en(rd_en), .rewind(rewind), .full(full), .empty(empty),
    .almost_empty(almost_empty), .almost_full(almost_full),
    .wr_bin(wr_bin), .rd_bin(rd_bin), .wr_gray(wr_gray),
    .wr_level(wr_level), .rd_level(rd_level)
);

// File: tb/test_xclk_fifo.sv
// Bench for xclk_fifo: shared 50 MHz clock, behavioural model stepped on
// every rising edge and compared in the middle of each low phase.
module test_xclk_fifo;

    localparam int W   = 18;
    localparam int D   = 16;
    localparam int OFS = 3;
    localparam int AW  = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
    logic          out_en_n = 1'b0, flag_sync = 1'b0;
    logic          ae_load = 1'b0, af_load = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic [AW-1:0] ae_level = '0, af_level = '0;
    wire  [W-1:0]  rd_data;
    logic          empty, full, half_full, almost_empty, almost_full;

    xclk_fifo #(.WIDTH(W), .DEPTH(D), .OFS_RESET(OFS)) i_xclk_fifo (
        .clk_w(clk), .clk_r(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind),
        .out_en_n(out_en_n), .rd_data(rd_data), .flag_sync(flag_sync),
        .ae_load(ae_load), .ae_level(ae_level), .af_load(af_load),
        .af_level(af_level), .empty(empty), .full(full),
        .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model state
    int wtot, rtot, ws1, ws2, rs1, rs2, aeo, afo, cw, cr;
    logic [W-1:0] store [D];
    logic [W-1:0] q_m;
    bit ae_q, af_q, full_p, empty_p;

    // Step the model on each rising edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            wtot = 0; rtot = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
            aeo = OFS; afo = OFS; ae_q = 1; af_q = 0; q_m = '0;
        end else begin
            cw = wtot - rs2;
            cr = ws2 - rtot;
            full_p  = (cw == D);
            empty_p = (cr == 0);
            ae_q = (cr <= aeo);
            af_q = (cw >= D - afo);
            ws2 = ws1; ws1 = wtot;
            rs2 = rs1; rs1 = rtot;
            if (wr_en && !full_p) begin
                store[wtot % D] = wr_data;
                wtot++;
            end
            if (rewind) rtot = 0;
            else if (rd_en && !empty_p) begin
                q_m = store[rtot % D];
                rtot++;
            end
            if (ae_load) aeo = int'(ae_level);
            if (af_load) afo = int'(af_level);
        end
    end

    // Compare every output with the model in the low phase
    always @(negedge clk) begin
        #3;
        if (started && !done) begin
            int lw, lr;
            bit e_ae, e_af;
            lw = wtot - rs2;
            lr = ws2 - rtot;
            e_ae = flag_sync ? ae_q : (lr <= aeo);
            e_af = flag_sync ? af_q : (lw >= D - afo);
            check(empty == (lr == 0), "R4 empty", 32'(empty), 32'(lr == 0));
            check(full == (lw == D), "R5 full", 32'(full), 32'(lw == D));
            check(half_full == (lw >= D/2 + 1), "R7 half_full",
                  32'(half_full), 32'(lw >= D/2 + 1));
            check(almost_empty == e_ae, flag_sync ? "R10 almost_empty" : "R8 almost_empty",
                  32'(almost_empty), 32'(e_ae));
            check(almost_full == e_af, flag_sync ? "R10 almost_full" : "R8 almost_full",
                  32'(almost_full), 32'(e_af));
            if (out_en_n)
                check(rd_data === {W{1'bz}}, "R3 tri-state", 32'(rd_data), 32'h3ffff);
            else
                check(rd_data === q_m, "R2 read data", 32'(rd_data), 32'(q_m));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [W-1:0] d);
        wr_en = 1'b1; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        #4;
        // R12 reset state
        check(empty && !full && almost_empty && !almost_full && rd_data == '0,
              "R12 reset state", {27'd0, empty, full, almost_empty, almost_full, 1'b0}, 32'h14);
        tick(1);

        // Single word: R2 first word after empty
        put(18'h12345);
        tick(4);
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        #4 check(rd_data == 18'h12345, "R2 first word", 32'(rd_data), 32'h12345);
        tick(1);

        // Overflow past DEPTH
        for (int i = 0; i < D + 4; i++) begin
            wr_en = 1'b1; wr_data = W'(32'h100 + i); tick(1);
        end
        wr_en = 1'b0;
        tick(3);
        #4 check(full == 1'b1, "R1 holds DEPTH words", 32'(full), 32'd1);
        rd_en = 1'b1; tick(D + 4); rd_en = 1'b0;
        tick(3);
        #4 check(rd_data == 18'h10f && empty, "R6 drops extra writes and reads",
                 32'(rd_data), 32'h10f);
        tick(1);

        // Streaming with concurrent read and write
        for (int i = 0; i < 30; i++) begin
            wr_en = 1'b1; wr_data = W'(i * 37 + 5); rd_en = (i % 3 != 0);
            tick(1);
        end
        wr_en = 1'b0; rd_en = 1'b1; tick(25); rd_en = 1'b0;
        tick(3);

        // Thresholds
        for (int i = 0; i < 4; i++) put(W'(32'h300 + i));
        tick(3);
        #4 check(almost_empty == 1'b0, "R9 default empty threshold", 32'(almost_empty), 32'd0);
        ae_level = 4'd5; ae_load = 1'b1; tick(1); ae_load = 1'b0;
        #4 check(almost_empty == 1'b1, "R9 loaded empty threshold", 32'(almost_empty), 32'd1);
        af_level = 4'd2; af_load = 1'b1; tick(1); af_load = 1'b0;
        for (int m = 1; m >= 0; m--) begin
            flag_sync = m[0];
            for (int i = 0; i < D; i++) begin put(W'(32'h400 + i)); tick(1); end
            tick(3);
            for (int i = 0; i < D; i++) begin
                rd_en = 1'b1; tick(1); rd_en = 1'b0; tick(1);
            end
            tick(3);
        end
        flag_sync = 1'b0;

        // Rewind after reset
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
        for (int i = 0; i < 6; i++) put(W'(32'h200 + i));
        tick(4);
        rd_en = 1'b1; tick(3); rd_en = 1'b0;
        tick(2);
        rewind = 1'b1; tick(1); rewind = 1'b0;
        tick(3);
        rd_en = 1'b1; tick(1); rd_en = 1'b0;
        #4 check(rd_data == 18'h200, "R11 replay from first word", 32'(rd_data), 32'h200);
        rd_en = 1'b1; tick(5); rd_en = 1'b0;
        tick(3);
        #4 check(rd_data == 18'h205 && empty, "R11 replay to last word", 32'(rd_data), 32'h205);
        tick(1);

        // Output enable
        put(18'h3aaaa);
        tick(3);
        out_en_n = 1'b1; tick(1);
        #4 check(rd_data === {W{1'bz}}, "R3 high impedance", 32'(rd_data), 32'h3ffff);
        rd_en = 1'b1; tick(1); rd_en = 1'b0; out_en_n = 1'b0; tick(1);
        #4 check(rd_data == 18'h3aaaa, "R3 read while disabled", 32'(rd_data), 32'h3aaaa);
        tick(2);
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

endmodule